// File: doc/BRIEF.md
# Receive Status and Error Tally

This block sits beside the receive path of an Ethernet-style MAC. The receive logic sends it one-cycle event strobes: frame start, frame end, CRC failure, a frame end that is not on a whole byte, FIFO overflow and no free buffer. It also gets levels for the address class of the frame, monitor mode, carrier sense and collision. From these it builds an 8-bit status byte that the host can read at any time. At the end of each frame it decides whether that byte should be stored in front of the frame in buffer memory.

Three saturating 8-bit tallies count alignment errors, plain CRC errors and missed frames. Network management software can then poll them at its own pace. A tally clears when the host reads it. An error that lands in the same cycle as the read is kept as the new count.

Top module: `rxstat_tally`

## Requirements
- R1: During reset and on the first cycle after it, `status_o` is 0x00, `wb_req_o` is 0 and every tally in `tally_o` is 0.
- R2: A `frm_start_i` pulse outside a frame opens a frame. It clears status bits 0 to 5 and stores `mcast_i` in bit 5 (0 = physical address match, 1 = multicast or broadcast match).
- R3: A frame end with `crc_bad_i` high and `dribble_i` low sets bit 1 (CRC) and adds one to tally 1 (bits 15:8 of `tally_o`).
- R4: A frame end with both `crc_bad_i` and `dribble_i` high sets bit 2 (alignment) and also bit 1, and adds one to tally 0 (bits 7:0) only. `dribble_i` with a good CRC counts as a good frame.
- R5: `fifo_ovf_i` inside a frame sets bit 3 (overrun) and closes the frame at once. A later `frm_end_i` for that frame has no effect.
- R6: At frame end, `no_buf_i` high or monitor mode on sets bit 4 (missed), adds one to tally 2 (bits 23:16) and requests no write-back.
- R7: Bit 0 (intact) is set after a frame closes only when bits 1 to 4 are all 0.
- R8: Bit 6 shows `monitor_i` and bit 7 shows `crs_i | col_i`, each one clock after the input.
- R9: `wb_req_o` is a one-cycle pulse in the cycle after a frame closes. It is raised for every intact frame and for a CRC, alignment or overrun frame only when `keep_err_i` is high. It is never raised for a missed frame.
- R10: A tally stops at 255 and does not wrap.
- R11: Pulsing a bit of `tally_rd_i` shows the current tally on `tally_o` in that cycle and clears it at the next edge. If an increment falls in the same cycle, the tally becomes 1.
- R12: `frm_end_i` and `fifo_ovf_i` outside a frame change no status bit, no tally and no write-back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frm_start_i | input | 1 | Frame start strobe |
| frm_end_i | input | 1 | Frame end strobe |
| crc_bad_i | input | 1 | CRC check failed, valid with frame end |
| dribble_i | input | 1 | Frame ended off a byte boundary, valid with frame end |
| fifo_ovf_i | input | 1 | Receive FIFO overflow strobe |
| no_buf_i | input | 1 | No receive buffer, valid with frame end |
| mcast_i | input | 1 | Address class, valid with frame start |
| monitor_i | input | 1 | Monitor mode level |
| crs_i | input | 1 | Carrier sense level |
| col_i | input | 1 | Collision level |
| keep_err_i | input | 1 | Store errored frames |
| tally_rd_i | input | 3 | Read strobes, one per tally |
| status_o | output | 8 | Status byte |
| wb_req_o | output | 1 | Status write-back request pulse |
| tally_o | output | 24 | Three 8-bit tallies, tally 0 in the low byte |

## Verification
A host read and a tally increment can fall in the same clock cycle. The bench provokes this by pulsing the read strobe of tally 1 in the same cycle as a CRC-failing frame end. It judges the result by expecting the old count on the output in that cycle and exactly 1 after the edge. The saturation run then drives more than 255 CRC frames to show the count stays at 255. A scoreboard queue pairs each write-back pulse with the status byte predicted by the driver.

// File: rtl/rxstat_pkg.sv
package rxstat_pkg;
  localparam int NUM_TALLY = 3;
  localparam int STAT_W    = 8;

  // status bit positions
  localparam int B_INTACT = 0;
  localparam int B_CRC    = 1;
  localparam int B_ALIGN  = 2;
  localparam int B_OVR    = 3;
  localparam int B_MISS   = 4;
  localparam int B_MCAST  = 5;
  localparam int B_RXOFF  = 6;
  localparam int B_DEFER  = 7;

  // tally indices
  localparam int T_ALIGN = 0;
  localparam int T_CRC   = 1;
  localparam int T_MISS  = 2;

  typedef struct packed {
    logic deferring;
    logic rx_off;
    logic mcast;
    logic missed;
    logic overrun;
    logic align;
    logic crc;
    logic intact;
  } rx_status_t;
endpackage

// File: rtl/rxstat_capture.sv
module rxstat_capture
  import rxstat_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 frm_start_i,
  input  logic                 frm_end_i,
  input  logic                 crc_bad_i,
  input  logic                 dribble_i,
  input  logic                 fifo_ovf_i,
  input  logic                 no_buf_i,
  input  logic                 mcast_i,
  input  logic                 monitor_i,
  input  logic                 keep_err_i,
  output logic [5:0]           frm_bits_o,
  output logic                 wb_req_o,
  output logic [NUM_TALLY-1:0] bump_o
);
  logic       in_frame;
  logic [5:0] bits_q;
  logic       wb_q;

  logic abort_now, close_now, open_now;
  logic is_align, is_crc_only, is_missed, is_bad;

  always_comb begin
    abort_now   = in_frame && fifo_ovf_i;
    close_now   = in_frame && frm_end_i && !fifo_ovf_i;
    open_now    = frm_start_i && !abort_now && !close_now;
    is_align    = crc_bad_i && dribble_i;
    is_crc_only = crc_bad_i && !dribble_i;
    is_missed   = no_buf_i || monitor_i;
    is_bad      = crc_bad_i || is_missed;
  end

  always_comb begin
    bump_o = '0;
    if (close_now) begin
      bump_o[T_ALIGN] = is_align;
      bump_o[T_CRC]   = is_crc_only;
      bump_o[T_MISS]  = is_missed;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      in_frame <= 1'b0;
      bits_q   <= '0;
      wb_q     <= 1'b0;
    end else begin
      wb_q <= 1'b0;
      if (abort_now) begin
        in_frame         <= 1'b0;
        bits_q[B_OVR]    <= 1'b1;
        bits_q[B_INTACT] <= 1'b0;
        wb_q             <= keep_err_i;
      end else if (close_now) begin
        in_frame         <= 1'b0;
        bits_q[B_CRC]    <= crc_bad_i;
        bits_q[B_ALIGN]  <= is_align;
        bits_q[B_MISS]   <= is_missed;
        bits_q[B_INTACT] <= !is_bad;
        wb_q             <= !is_missed && (!crc_bad_i || keep_err_i);
      end else if (open_now) begin
        in_frame <= 1'b1;
        bits_q   <= {mcast_i, 5'b0};
      end
    end
  end

  assign frm_bits_o = bits_q;
  assign wb_req_o   = wb_q;
endmodule

// File: rtl/rxstat_live.sv
module rxstat_live (
  input  logic clk,
  input  logic rst,
  input  logic monitor_i,
  input  logic crs_i,
  input  logic col_i,
  output logic rx_off_o,
  output logic defer_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rx_off_o <= 1'b0;
      defer_o  <= 1'b0;
    end else begin
      rx_off_o <= monitor_i;
      defer_o  <= crs_i || col_i;
    end
  end
endmodule

// File: rtl/rxstat_counter.sv
module rxstat_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         bump_i,
  input  logic         rd_i,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] TOP = '1;
  localparam logic [W-1:0] ONE = W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_o <= '0;
    end else if (rd_i) begin
      cnt_o <= bump_i ? ONE : '0;
    end else if (bump_i && cnt_o != TOP) begin
      cnt_o <= cnt_o + ONE;
    end
  end
endmodule

// File: rtl/rxstat_tally.sv
module rxstat_tally
  import rxstat_pkg::*;
#(
  parameter int TALLY_W = 8
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         frm_start_i,
  input  logic                         frm_end_i,
  input  logic                         crc_bad_i,
  input  logic                         dribble_i,
  input  logic                         fifo_ovf_i,
  input  logic                         no_buf_i,
  input  logic                         mcast_i,
  input  logic                         monitor_i,
  input  logic                         crs_i,
  input  logic                         col_i,
  input  logic                         keep_err_i,
  input  logic [NUM_TALLY-1:0]         tally_rd_i,
  output logic [STAT_W-1:0]            status_o,
  output logic                         wb_req_o,
  output logic [NUM_TALLY*TALLY_W-1:0] tally_o
);
  logic [5:0]           frm_bits;
  logic [NUM_TALLY-1:0] bump;
  logic                 rx_off, defer;
  rx_status_t           stat;

  rxstat_capture u_cap (
    .clk         (clk),
    .rst         (rst),
    .frm_start_i (frm_start_i),
    .frm_end_i   (frm_end_i),
    .crc_bad_i   (crc_bad_i),
    .dribble_i   (dribble_i),
    .fifo_ovf_i  (fifo_ovf_i),
    .no_buf_i    (no_buf_i),
    .mcast_i     (mcast_i),
    .monitor_i   (monitor_i),
    .keep_err_i  (keep_err_i),
    .frm_bits_o  (frm_bits),
    .wb_req_o    (wb_req_o),
    .bump_o      (bump)
  );

  rxstat_live u_live (
    .clk       (clk),
    .rst       (rst),
    .monitor_i (monitor_i),
    .crs_i     (crs_i),
    .col_i     (col_i),
    .rx_off_o  (rx_off),
    .defer_o   (defer)
  );

  for (genvar g = 0; g < NUM_TALLY; g++) begin : g_tally
    rxstat_counter #(.W(TALLY_W)) u_cnt (
      .clk    (clk),
      .rst    (rst),
      .bump_i (bump[g]),
      .rd_i   (tally_rd_i[g]),
      .cnt_o  (tally_o[g*TALLY_W +: TALLY_W])
    );
  end

  always_comb begin
    stat           = '0;
    stat.intact    = frm_bits[B_INTACT];
    stat.crc       = frm_bits[B_CRC];
    stat.align     = frm_bits[B_ALIGN];
    stat.overrun   = frm_bits[B_OVR];
    stat.missed    = frm_bits[B_MISS];
    stat.mcast     = frm_bits[B_MCAST];
    stat.rx_off    = rx_off;
    stat.deferring = defer;
  end

  assign status_o = stat;
endmodule

// File: rtl/rxstat_tally_chk.sv
module rxstat_tally_chk
  import rxstat_pkg::*;
#(
  parameter int TALLY_W = 8
) (
  input logic                         clk,
  input logic                         rst,
  input logic                         monitor_i,
  input logic                         crs_i,
  input logic                         col_i,
  input logic                         keep_err_i,
  input logic [NUM_TALLY-1:0]         tally_rd_i,
  input logic [STAT_W-1:0]            status_o,
  input logic                         wb_req_o,
  input logic [NUM_TALLY*TALLY_W-1:0] tally_o
);
  localparam logic [TALLY_W-1:0] TMAX = '1;

  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (status_o == '0 && !wb_req_o && tally_o == '0));

  assert_align_sets_crc_R4: assert property (@(posedge clk) disable iff (rst)
    status_o[B_ALIGN] |-> status_o[B_CRC]);

  assert_intact_clean_R7: assert property (@(posedge clk) disable iff (rst)
    status_o[B_INTACT] |-> (status_o[B_MISS:B_CRC] == '0));

  assert_rxoff_follows_R8: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (status_o[B_RXOFF] == $past(monitor_i)));

  assert_defer_follows_R8: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (status_o[B_DEFER] == $past(crs_i || col_i)));

  assert_wb_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    wb_req_o |=> !wb_req_o);

  assert_wb_allowed_R9: assert property (@(posedge clk) disable iff (rst)
    wb_req_o |-> (!status_o[B_MISS] && (status_o[B_INTACT] || $past(keep_err_i))));

  for (genvar g = 0; g < NUM_TALLY; g++) begin : g_chk
    assert_no_wrap_R10: assert property (@(posedge clk) disable iff (rst)
      (!tally_rd_i[g] && tally_o[g*TALLY_W +: TALLY_W] == TMAX)
        |=> tally_o[g*TALLY_W +: TALLY_W] == TMAX);

    assert_read_clears_R11: assert property (@(posedge clk) disable iff (rst)
      tally_rd_i[g] |=> tally_o[g*TALLY_W +: TALLY_W] <= TALLY_W'(1));
  end
endmodule

bind rxstat_tally rxstat_tally_chk #(.TALLY_W(TALLY_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .monitor_i  (monitor_i),
  .crs_i      (crs_i),
  .col_i      (col_i),
  .keep_err_i (keep_err_i),
  .tally_rd_i (tally_rd_i),
  .status_o   (status_o),
  .wb_req_o   (wb_req_o),
  .tally_o    (tally_o)
);

// File: tb/rxstat_tally_test.sv
module rxstat_tally_test;
  timeunit 1ns;
  timeprecision 100ps;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        frm_start_i = 0, frm_end_i = 0, crc_bad_i = 0, dribble_i = 0;
  logic        fifo_ovf_i = 0, no_buf_i = 0, mcast_i = 0, monitor_i = 0;
  logic        crs_i = 0, col_i = 0, keep_err_i = 0;
  logic [2:0]  tally_rd_i = '0;
  logic [7:0]  status_o;
  logic        wb_req_o;
  logic [23:0] tally_o;

  int total = 0;
  int bad   = 0;
  bit done  = 0;
  int m_tal [3];
  logic [7:0] exp_q [$];
  logic [7:0] last_exp;

  rxstat_tally uut (
    .clk(clk), .rst(rst), .frm_start_i(frm_start_i), .frm_end_i(frm_end_i),
    .crc_bad_i(crc_bad_i), .dribble_i(dribble_i), .fifo_ovf_i(fifo_ovf_i),
    .no_buf_i(no_buf_i), .mcast_i(mcast_i), .monitor_i(monitor_i),
    .crs_i(crs_i), .col_i(col_i), .keep_err_i(keep_err_i),
    .tally_rd_i(tally_rd_i), .status_o(status_o), .wb_req_o(wb_req_o),
    .tally_o(tally_o)
  );

  always #2.5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: each write-back pulse must match the next queued status
  always @(negedge clk) begin
    if (!rst && wb_req_o) begin
      if (exp_q.size() == 0) chk("R9 unexpected write-back", 1, 0);
      else chk("R9 write-back status", {24'h0, status_o}, {24'h0, exp_q.pop_front()});
    end
  end

  function automatic int sat_inc(input int v);
    return (v < 255) ? v + 1 : v;
  endfunction

  // driver: one frame, with prediction pushed to the scoreboard
  task automatic send_frm(input logic mc, input logic crc, input logic drib,
                          input logic nob, input logic ovf, input string req);
    logic [7:0] e;
    logic miss, wb;
    frm_start_i = 1; mcast_i = mc;
    @(negedge clk);
    frm_start_i = 0; mcast_i = 0;
    e = '0;
    e[7] = crs_i | col_i;
    e[6] = monitor_i;
    e[5] = mc;
    if (ovf) begin
      e[3] = 1'b1;
      wb = keep_err_i;
      fifo_ovf_i = 1;
    end else begin
      miss = nob | monitor_i;
      e[1] = crc;
      e[2] = crc & drib;
      e[4] = miss;
      e[0] = !(crc | miss);
      wb = !miss && (!crc || keep_err_i);
      frm_end_i = 1; crc_bad_i = crc; dribble_i = drib; no_buf_i = nob;
      if (crc && drib)  m_tal[0] = sat_inc(m_tal[0]);
      if (crc && !drib) m_tal[1] = sat_inc(m_tal[1]);
      if (miss)         m_tal[2] = sat_inc(m_tal[2]);
    end
    if (wb) exp_q.push_back(e);
    @(negedge clk);
    frm_end_i = 0; crc_bad_i = 0; dribble_i = 0; no_buf_i = 0; fifo_ovf_i = 0;
    chk(req, {24'h0, status_o}, {24'h0, e});
    if (!wb) chk({req, " no write-back (R9)"}, {31'h0, wb_req_o}, 0);
    last_exp = e;
  endtask

  task automatic read_tally(input int i, input string req);
    tally_rd_i[i] = 1'b1;
    chk(req, {24'h0, tally_o[i*8 +: 8]}, m_tal[i]);
    @(negedge clk);
    tally_rd_i = '0;
    m_tal[i] = 0;
    chk({req, " cleared"}, {24'h0, tally_o[i*8 +: 8]}, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 3; i++) m_tal[i] = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    chk("R1 status after reset", {24'h0, status_o}, 0);
    chk("R1 wb after reset", {31'h0, wb_req_o}, 0);
    chk("R1 tallies after reset", {8'h0, tally_o}, 0);

    // good frames
    send_frm(0, 0, 0, 0, 0, "R7 R2 good physical");
    send_frm(1, 0, 0, 0, 0, "R2 good multicast");
    send_frm(0, 0, 1, 0, 0, "R4 dribble with good CRC is intact");

    // errored frames, not kept
    send_frm(0, 1, 0, 0, 0, "R3 CRC error");
    send_frm(1, 1, 1, 0, 0, "R4 alignment error");
    // errored frames, kept
    keep_err_i = 1;
    send_frm(0, 1, 0, 0, 0, "R9 kept CRC error");
    send_frm(1, 0, 0, 0, 1, "R5 overrun kept");
    keep_err_i = 0;
    send_frm(0, 0, 0, 0, 1, "R5 overrun not kept");

    // late end after abort and stray overflow: ignored
    frm_end_i = 1; crc_bad_i = 1; no_buf_i = 1;
    @(negedge clk);
    frm_end_i = 0; crc_bad_i = 0; no_buf_i = 0;
    chk("R5 R12 end after abort ignored", {24'h0, status_o}, {24'h0, last_exp});
    chk("R12 no wb for stray end", {31'h0, wb_req_o}, 0);
    fifo_ovf_i = 1;
    @(negedge clk);
    fifo_ovf_i = 0;
    chk("R12 stray overflow ignored", {24'h0, status_o}, {24'h0, last_exp});

    // missed frames
    send_frm(0, 0, 0, 1, 0, "R6 missed, no buffer");
    monitor_i = 1;
    @(negedge clk);
    chk("R8 receiver-off bit set", {31'h0, status_o[6]}, 1);
    send_frm(1, 0, 0, 0, 0, "R6 missed in monitor mode");
    monitor_i = 0;
    @(negedge clk);
    chk("R8 receiver-off bit cleared", {31'h0, status_o[6]}, 0);

    // deferral
    crs_i = 1;
    @(negedge clk);
    chk("R8 deferring on carrier", {31'h0, status_o[7]}, 1);
    crs_i = 0; col_i = 1;
    @(negedge clk);
    chk("R8 deferring on collision", {31'h0, status_o[7]}, 1);
    send_frm(0, 0, 0, 0, 0, "R8 good frame while deferring");
    col_i = 0;
    @(negedge clk);
    chk("R8 deferring cleared", {31'h0, status_o[7]}, 0);

    // tally reads
    read_tally(0, "R11 R4 alignment tally");
    read_tally(1, "R11 R3 CRC tally");
    read_tally(2, "R11 R6 missed tally");

    // read and increment in one cycle
    send_frm(0, 1, 0, 0, 0, "R3 CRC before collision test");
    frm_start_i = 1;
    @(negedge clk);
    frm_start_i = 0;
    frm_end_i = 1; crc_bad_i = 1; tally_rd_i[1] = 1'b1;
    chk("R11 read value in same cycle as increment", {24'h0, tally_o[15:8]}, m_tal[1]);
    @(negedge clk);
    frm_end_i = 0; crc_bad_i = 0; tally_rd_i = '0;
    m_tal[1] = 1;
    chk("R11 increment kept across read", {24'h0, tally_o[15:8]}, 1);

    // saturation
    for (int n = 0; n < 258; n++) send_frm(0, 1, 0, 0, 0, "R3 CRC burst");
    chk("R10 CRC tally saturates", {24'h0, tally_o[15:8]}, 255);
    send_frm(0, 1, 0, 0, 0, "R3 CRC past saturation");
    chk("R10 CRC tally stays at 255", {24'h0, tally_o[15:8]}, 255);
    chk("R10 other tallies untouched", {24'h0, tally_o[7:0]}, m_tal[0]);

    repeat (2) @(negedge clk);
    chk("R9 every predicted write-back seen", exp_q.size(), 0);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule